// File: doc/BRIEF.md
# Wide Significand Normalizer

This block brings an unpacked floating-point operand into a canonical form before further arithmetic. The operand carries a 3-bit class code, a sign, a 32-bit signed exponent and a 128-bit significand viewed as four 32-bit words with the most significant word on top. For a normal operand, the significand is shifted so that its most significant set bit lands at bit 112, which gives a 113-bit extended significand. The exponent is adjusted so that the value the operand represents is preserved.

Operands of any other class go through untouched. A normal operand whose significand is entirely zero is re-tagged as zero. The shift and the exponent correction are computed in one combinational pass: a leading-one detector finds the position p of the top set bit, and a logarithmic barrel shifter moves it to bit 112. The net exponent change is p − 112. This equals the combined effect of a per-word adjustment of −32 for each empty top word and a per-bit adjustment for the final fine shift.

Operands enter through a valid/ready handshake. Each result is held in a single registered output stage, which also carries back-pressure.

Top module: `sig_normalizer`

## Requirements
- R1: While reset is asserted, and directly after it, `out_valid` is 0 and `in_ready` is 1.
- R2: An operand whose class is not normal (codes: zero=0, normal=1, infinity=2, quiet NaN=3, signaling NaN=4) is output with its class, exponent and significand unchanged.
- R3: A normal operand (class code 1) whose 128-bit significand is all zero leaves with class code 0, and with its exponent and significand unchanged.
- R4: A normal operand with a nonzero significand leaves with class code 1, bit 112 of the significand set, and bits 127..113 clear. An operand whose top word (bits 127..96) is already between 0x10000 and 0x1FFFF is unchanged.
- R5: For a normal nonzero operand whose top set bit is at position p, the output exponent is the input exponent + p − 112, modulo 2^32. Each all-zero top word contributes −32.
- R6: When the top word is 0x20000 or larger, the significand shifts right by p − 112. Bits shifted out of bit 0 are dropped, and no sticky or round bit is kept.
- R7: When the top set bit is below bit 112, the significand shifts left by 112 − p, and zeros fill from bit 0.
- R8: An operand accepted at a rising clock edge (in_valid and in_ready both 1) appears with `out_valid` = 1 directly after that edge.
- R9: `in_ready` equals NOT out_valid OR out_ready. While out_valid is 1 and out_ready is 0, every output holds its value.
- R10: The sign bit is carried from input to output unchanged for every class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input operand present |
| in_ready | output | 1 | Block can take an operand this cycle |
| in_class | input | 3 | Class code of the input operand |
| in_sign | input | 1 | Sign of the input operand |
| in_exp | input | 32 | Signed exponent of the input operand |
| in_sig | input | 128 | Significand, bits 127..96 form the top word |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_class | output | 3 | Class code of the result |
| out_sign | output | 1 | Sign of the result |
| out_exp | output | 32 | Adjusted exponent |
| out_sig | output | 128 | Normalized significand |

## Verification
Every result is due exactly one rising edge after its operand is accepted, and it leaves at the first edge where out_ready is 1. The bench drives inputs and samples outputs at the falling edge. It settles each handshake a short delay after driving, so a result expected from an acceptance is checked at the next falling edge. A queue of results from an iterative word-then-bit shift model is compared in order on every output transfer. While out_ready is held low, the bench also checks each cycle that the held result has not moved and that `in_ready` follows the back-pressure rule.

// File: rtl/norm_pkg.sv
package norm_pkg;
  localparam int CLS_W = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_ZERO   = 3'd0,
    CLS_NORMAL = 3'd1,
    CLS_INF    = 3'd2,
    CLS_QNAN   = 3'd3,
    CLS_SNAN   = 3'd4
  } num_class_e;
endpackage

// File: rtl/norm_lead_detect.sv
module norm_lead_detect #(
  parameter int SIG_W  = 128,
  parameter int WORD_W = 32,
  parameter int POS_W  = $clog2(SIG_W)
) (
  input  logic [SIG_W-1:0] din,
  output logic             any_set,
  output logic [POS_W-1:0] lead
);
  localparam int NW     = SIG_W / WORD_W;
  localparam int BIT_W  = $clog2(WORD_W);
  localparam int WSEL_W = $clog2(NW);

  logic [NW-1:0]    w_any;
  logic [BIT_W-1:0] w_pos [NW];

  // per-word priority encoders, lowest bit first so the top set bit wins
  for (genvar w = 0; w < NW; w++) begin : g_word
    logic [BIT_W-1:0] pos_l;
    always_comb begin
      pos_l = '0;
      for (int b = 0; b < WORD_W; b++) begin
        if (din[w*WORD_W + b]) pos_l = BIT_W'(b);
      end
    end
    assign w_any[w] = |din[w*WORD_W +: WORD_W];
    assign w_pos[w] = pos_l;
  end

  // word select: highest non-empty word gives the upper index bits
  always_comb begin
    any_set = |w_any;
    lead    = '0;
    for (int w = 0; w < NW; w++) begin
      if (w_any[w]) lead = {WSEL_W'(w), w_pos[w]};
    end
  end
endmodule

// File: rtl/norm_shift.sv
module norm_shift #(
  parameter int SIG_W    = 128,
  parameter int LEAD_POS = 112,
  parameter int POS_W    = $clog2(SIG_W)
) (
  input  logic [SIG_W-1:0] din,
  input  logic [POS_W-1:0] lead,
  output logic [SIG_W-1:0] dout
);
  localparam int L_AMT_W = $clog2(LEAD_POS + 1);
  localparam int R_SPAN  = SIG_W - LEAD_POS;
  localparam int R_AMT_W = (R_SPAN > 1) ? $clog2(R_SPAN) : 1;

  logic             go_right;
  logic [POS_W:0]   diff_l;
  logic [POS_W:0]   diff_r;
  logic [L_AMT_W-1:0] l_amt;
  logic [R_AMT_W-1:0] r_amt;

  assign go_right = {1'b0, lead} > (POS_W+1)'(LEAD_POS);
  assign diff_l   = (POS_W+1)'(LEAD_POS) - {1'b0, lead};
  assign diff_r   = {1'b0, lead} - (POS_W+1)'(LEAD_POS);
  assign l_amt    = diff_l[L_AMT_W-1:0];
  assign r_amt    = diff_r[R_AMT_W-1:0];

  logic [SIG_W-1:0] lstg [L_AMT_W+1];
  logic [SIG_W-1:0] rstg [R_AMT_W+1];

  assign lstg[0] = din;
  assign rstg[0] = din;

  // left path: zeros enter from bit 0
  for (genvar s = 0; s < L_AMT_W; s++) begin : g_left
    assign lstg[s+1] = l_amt[s] ? (lstg[s] << (1 << s)) : lstg[s];
  end

  // right path: low bits fall off, nothing is kept
  for (genvar s = 0; s < R_AMT_W; s++) begin : g_right
    assign rstg[s+1] = r_amt[s] ? (rstg[s] >> (1 << s)) : rstg[s];
  end

  assign dout = go_right ? rstg[R_AMT_W] : lstg[L_AMT_W];
endmodule

// File: rtl/sig_normalizer.sv
module sig_normalizer
  import norm_pkg::*;
#(
  parameter int SIG_W    = 128,
  parameter int WORD_W   = 32,
  parameter int EXP_W    = 32,
  parameter int LEAD_POS = 112
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [CLS_W-1:0] in_class,
  input  logic             in_sign,
  input  logic [EXP_W-1:0] in_exp,
  input  logic [SIG_W-1:0] in_sig,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [CLS_W-1:0] out_class,
  output logic             out_sign,
  output logic [EXP_W-1:0] out_exp,
  output logic [SIG_W-1:0] out_sig
);
  localparam int POS_W = $clog2(SIG_W);

  logic             any_set;
  logic [POS_W-1:0] lead;
  logic [SIG_W-1:0] shifted;

  norm_lead_detect #(.SIG_W(SIG_W), .WORD_W(WORD_W), .POS_W(POS_W)) u_lead (
    .din     (in_sig),
    .any_set (any_set),
    .lead    (lead)
  );

  norm_shift #(.SIG_W(SIG_W), .LEAD_POS(LEAD_POS), .POS_W(POS_W)) u_shift (
    .din  (in_sig),
    .lead (lead),
    .dout (shifted)
  );

  // next-state logic
  logic             load;
  logic             valid_nxt;
  logic [CLS_W-1:0] cls_nxt;
  logic [EXP_W-1:0] exp_nxt;
  logic [SIG_W-1:0] sig_nxt;

  assign in_ready = !out_valid || out_ready;
  assign load     = in_valid && in_ready;

  always_comb begin
    valid_nxt = out_valid;
    if (load)           valid_nxt = 1'b1;
    else if (out_ready) valid_nxt = 1'b0;
  end

  always_comb begin
    cls_nxt = in_class;
    exp_nxt = in_exp;
    sig_nxt = in_sig;
    if (in_class == CLS_NORMAL) begin
      if (!any_set) begin
        cls_nxt = CLS_ZERO;
      end else begin
        sig_nxt = shifted;
        exp_nxt = in_exp + EXP_W'(lead) - EXP_W'(LEAD_POS);
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= valid_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_class <= '0;
      out_sign  <= 1'b0;
      out_exp   <= '0;
      out_sig   <= '0;
    end else if (load) begin
      out_class <= cls_nxt;
      out_sign  <= in_sign;
      out_exp   <= exp_nxt;
      out_sig   <= sig_nxt;
    end
  end

  // checks
  a_r1_idle_after_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> !out_valid);

  a_r2_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    load && in_class != CLS_NORMAL |=>
      out_class == $past(in_class) && out_exp == $past(in_exp) && out_sig == $past(in_sig));

  a_r3_zero_retag: assert property (@(posedge clk) disable iff (!rst_n)
    load && in_class == CLS_NORMAL && in_sig == '0 |=>
      out_class == CLS_ZERO && out_exp == $past(in_exp) && out_sig == '0);

  a_r4_lead_at_target: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_class == CLS_NORMAL |->
      out_sig[LEAD_POS] && out_sig[SIG_W-1:LEAD_POS+1] == '0);

  a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> out_valid);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=>
      out_valid && $stable(out_sig) && $stable(out_exp) && $stable(out_class) && $stable(out_sign));

  a_r10_sign: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> out_sign == $past(in_sign));
endmodule

// File: tb/test_sig_normalizer.sv
module test_sig_normalizer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [2:0]   in_class;
  logic         in_sign;
  logic [31:0]  in_exp;
  logic [127:0] in_sig;
  logic         out_valid;
  logic         out_ready;
  logic [2:0]   out_class;
  logic         out_sign;
  logic [31:0]  out_exp;
  logic [127:0] out_sig;

  sig_normalizer i_sig_normalizer (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_class(in_class), .in_sign(in_sign), .in_exp(in_exp), .in_sig(in_sig),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_class(out_class), .out_sign(out_sign), .out_exp(out_exp), .out_sig(out_sig)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [2:0]   cls;
    logic         sgn;
    logic [31:0]  ex;
    logic [127:0] sg;
    logic [2:0]   src_cls;
    logic [127:0] src_sig;
  } ref_t;

  ref_t exp_q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  int   cycles   = 0;
  bit   rand_ready = 1'b0;
  bit   pend_lat   = 1'b0;
  bit   stalled    = 1'b0;
  ref_t held;

  // behavioural model: whole-word moves first, then single-bit moves
  function automatic ref_t model(logic [2:0] c, logic s, logic [31:0] e, logic [127:0] g);
    ref_t r;
    r.cls = c; r.sgn = s; r.ex = e; r.sg = g; r.src_cls = c; r.src_sig = g;
    if (c == 3'd1) begin
      if (g == '0) begin
        r.cls = 3'd0;
      end else begin
        while (r.sg[127:96] == 32'd0) begin
          r.sg = r.sg << 32;
          r.ex = r.ex - 32'd32;
        end
        while (r.sg[127:96] >= 32'h20000) begin
          r.sg = r.sg >> 1;
          r.ex = r.ex + 32'd1;
        end
        while (r.sg[127:96] < 32'h10000) begin
          r.sg = r.sg << 1;
          r.ex = r.ex - 32'd1;
        end
      end
    end
    return r;
  endfunction

  function automatic string sig_tag(ref_t r);
    if (r.src_cls != 3'd1)                  return "R2";
    if (r.src_sig == '0)                    return "R3";
    if (r.src_sig[127:96] >= 32'h20000)     return "R6";
    if (r.src_sig[127:96] < 32'h10000)      return "R7";
    return "R4";
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic compare_out();
    ref_t r;
    if (exp_q.size() == 0) begin
      check(1'b0, "R8", "unexpected result", {125'd0, out_class}, '0);
      return;
    end
    r = exp_q.pop_front();
    check(out_class == r.cls, sig_tag(r), "class", {125'd0, out_class}, {125'd0, r.cls});
    check(out_sig == r.sg, sig_tag(r), "significand", out_sig, r.sg);
    check(out_exp == r.ex, (r.src_cls == 3'd1 && r.src_sig != '0) ? "R5" : sig_tag(r),
          "exponent", {96'd0, out_exp}, {96'd0, r.ex});
    check(out_sign == r.sgn, "R10", "sign", {127'd0, out_sign}, {127'd0, r.sgn});
  endtask

  // one clock: check what the last edge produced, drive, then settle handshakes
  task automatic drive(input logic v, input logic [2:0] c, input logic s,
                       input logic [31:0] e, input logic [127:0] g, output bit acc);
    @(negedge clk);
    if (pend_lat)
      check(out_valid == 1'b1, "R8", "valid after accept", {127'd0, out_valid}, 128'd1);
    if (stalled) begin
      check(out_valid && out_sig == held.sg && out_exp == held.ex &&
            out_class == held.cls && out_sign == held.sgn,
            "R9", "hold under stall", out_sig, held.sg);
    end
    in_valid = v; in_class = c; in_sign = s; in_exp = e; in_sig = g;
    out_ready = rand_ready ? (($urandom % 3) != 0) : 1'b1;
    #1;
    check(in_ready == (!out_valid || out_ready), "R9", "in_ready rule",
          {127'd0, in_ready}, {127'd0, (!out_valid || out_ready)});
    stalled = out_valid && !out_ready;
    if (stalled) begin
      held.sg = out_sig; held.ex = out_exp; held.cls = out_class; held.sgn = out_sign;
    end
    if (out_valid && out_ready) compare_out();
    acc = v && in_ready;
    pend_lat = acc;
    if (acc) exp_q.push_back(model(c, s, e, g));
  endtask

  task automatic send(input logic [2:0] c, input logic s, input logic [31:0] e,
                      input logic [127:0] g);
    bit acc;
    do drive(1'b1, c, s, e, g, acc); while (!acc);
  endtask

  task automatic idle(input int n);
    bit acc;
    for (int i = 0; i < n; i++) drive(1'b0, 3'd0, 1'b0, 32'd0, '0, acc);
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under %0d", cycles, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [127:0] g;
    rst_n = 1'b0; in_valid = 1'b0; in_class = '0; in_sign = 1'b0;
    in_exp = '0; in_sig = '0; out_ready = 1'b1;
    #(CLK_PERIOD * 3);
    #1;
    // R1: reset state
    check(out_valid == 1'b0, "R1", "out_valid in reset", {127'd0, out_valid}, '0);
    check(in_ready == 1'b1, "R1", "in_ready in reset", {127'd0, in_ready}, 128'd1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", {127'd0, out_valid}, '0);

    // R2: non-normal classes pass through
    send(3'd0, 1'b1, 32'h1234, 128'h5);
    send(3'd2, 1'b0, 32'h7fff, rnd128());
    send(3'd3, 1'b1, 32'hffff_fff0, rnd128());
    send(3'd4, 1'b0, 32'd7, 128'h1);
    // R3: normal with empty significand
    send(3'd1, 1'b1, 32'h55, '0);
    // R4: already in range, boundaries of the top word
    send(3'd1, 1'b0, 32'd100, {32'h10000, 96'hdead_beef_0000_0001_8000_0000});
    send(3'd1, 1'b1, 32'd100, {32'h1ffff, 96'hffff_ffff_ffff_ffff_ffff_ffff});
    // R6: right shifts with discarded low bits
    send(3'd1, 1'b0, 32'd0, {32'h20000, 96'hffff_ffff_ffff_ffff_ffff_ffff});
    send(3'd1, 1'b1, 32'h7fff_fff8, {128{1'b1}});
    // R5/R7: leading one at every bit position, random bits below
    for (int k = 0; k < 128; k++) begin
      g = (128'd1 << k) | (rnd128() & ((128'd1 << k) - 128'd1));
      send(3'd1, k[0], $urandom, g);
    end
    // R7: smallest significand, exponent wraps
    send(3'd1, 1'b0, 32'h8000_0000, 128'd1);
    idle(3);

    // R9: random back-pressure with mixed traffic
    rand_ready = 1'b1;
    for (int i = 0; i < 400; i++) begin
      int pos;
      logic [2:0] c;
      pos = $urandom % 128;
      c = (($urandom % 4) == 0) ? 3'($urandom % 5) : 3'd1;
      g = (($urandom % 16) == 0) ? '0 : ((128'd1 << pos) | (rnd128() & ((128'd1 << pos) - 128'd1)));
      send(c, 1'($urandom), $urandom, g);
      if (($urandom % 5) == 0) idle(1 + ($urandom % 3));
    end
    rand_ready = 1'b0;
    idle(4);
    check(exp_q.size() == 0, "R8", "all results delivered", 128'(exp_q.size()), '0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule